// File: doc/BRIEF.md
# Registered Command/Address Buffer with Parity Checking

This block sits between a memory controller and the DRAM devices of a module. It takes a 25-bit command/address word, registers it on the rising clock edge, and drives the registered copy out. Two active-low select inputs qualify the capture: a word is taken only when both are low. While either select is high, the outputs keep their last value.

A parity bit comes in with every word. The block uses even parity across the 25 data bits and that bit, and runs the check in a short pipeline beside the data path. A one-bit partial-parity output shows the combined XOR of the last captured word one clock after capture. An active-low error output drops for one clock, two edges after a failing word was captured. The result can be read on the following edge. For a set number of clocks after reset release, error reporting is masked. This keeps the floating or settling inputs of that window from giving false alarms.

Top module: `sreg_parity_buffer`

## Requirements
- R1: When both `sel_dev_n` and `sel_reg_n` are low at a rising edge (with `rst_n` high), `q_out` takes the value of `d_in` at that edge.
- R2: When either select is high at an edge, `q_out` keeps its value, and the parity pipeline takes no sample: a bad parity bit offered on that cycle never drives `err_n` low.
- R3: One edge after a capture, `ppo` equals the XOR of the 25 captured data bits and the captured `par_in`. It holds that value until the next capture.
- R4: Parity is even. If a word captured at edge n has an odd count of ones across `d_in` and `par_in`, `err_n` is 0 after edge n+2. If the count is even, `err_n` is 1 after edge n+2.
- R5: An erroneous word holds `err_n` low for exactly one clock. If the word captured at the next edge is good, `err_n` returns to 1 after edge n+3.
- R6: Edges are counted with `rst_n` high since release. At an edge where that count is below `ACT_CYCLES`, `err_n` is driven to 1 whatever the parity result.
- R7: At an edge with `rst_n` low, `q_out` and `ppo` go to 0, `err_n` goes to 1, and the parity pipeline is cleared. A bad word captured just before reset is never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_dev_n | input | 1 | Device select, active low |
| sel_reg_n | input | 1 | Register select, active low |
| d_in | input | 25 | Command/address word |
| par_in | input | 1 | Even-parity bit for `d_in` |
| q_out | output | 25 | Registered word |
| ppo | output | 1 | XOR of last captured word and parity bit |
| err_n | output | 1 | Parity error flag, active low, one clock per bad word |

## Verification
Words are driven with all bits set, with one walking bit, with alternating bits and with random values. Each is sent with correct and with flipped parity, so a wrong latency or a wrong parity sense shows up on `err_n` and `ppo`. Back-to-back bad words, followed by a good one, show whether the error flag is a single-clock pulse rather than sticky. Bad parity is also offered on deselected cycles, to show that the pipeline skips them. It is offered again right after reset release, to show the activation mask. A bad word captured just before a mid-run reset shows whether the pipeline is cleared.

// File: rtl/sreg_pkg.sv
// Shared definitions for the registered parity buffer.
// Assumes: selects are active low and both must be asserted to capture.
package sreg_pkg;
    localparam int unsigned SREG_W_DEFAULT   = 25;
    localparam int unsigned SREG_ACT_DEFAULT = 8;

    // Capture qualifier: both active-low selects asserted.
    function automatic logic sel_active(input logic dev_n, input logic reg_n);
        return (~dev_n) & (~reg_n);
    endfunction
endpackage

// File: rtl/sreg_capture.sv
// Input register stage: holds the word, its parity bit and a capture flag.
// Assumes: cap is already qualified by the selects; synchronous active-low reset.
module sreg_capture #(
    parameter int unsigned W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap,
    input  logic [W-1:0] d,
    input  logic         par,
    output logic [W-1:0] q,
    output logic         par_q,
    output logic         cap_q
);
    // Register the word and parity on capture, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q     <= '0;
            par_q <= 1'b0;
            cap_q <= 1'b0;
        end else begin
            cap_q <= cap;
            if (cap) begin
                q     <= d;
                par_q <= par;
            end
        end
    end
endmodule

// File: rtl/sreg_act_window.sv
// Counts edges since reset release and masks error reporting until
// ACT_CYCLES edges have passed. Assumes ACT_CYCLES >= 1.
module sreg_act_window #(
    parameter int unsigned ACT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic masked
);
    localparam int unsigned CW = $clog2(ACT_CYCLES + 1);
    localparam logic [CW-1:0] LIMIT = CW'(ACT_CYCLES);

    logic [CW-1:0] cnt;

    // Saturating count of edges seen with reset released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt != LIMIT)
            cnt <= cnt + 1'b1;
    end

    // Mask stays on until the count reaches the limit.
    always_comb masked = (cnt < LIMIT);
endmodule

// File: rtl/sreg_parity_pipe.sv
// Parity check pipeline beside the data path. Stage 1 folds the captured
// word and parity bit into one odd/even result and drives ppo. Stage 2
// turns that result into the active-low error flag.
// Assumes: even parity; mask comes from the activation window.
module sreg_parity_pipe #(
    parameter int unsigned W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] q,
    input  logic         par_q,
    input  logic         cap_q,
    input  logic         mask,
    output logic         ppo,
    output logic         err_n
);
    logic odd_now;
    logic stg_vld;
    logic stg_odd;

    // Combined XOR of the captured word and its parity bit.
    always_comb odd_now = (^q) ^ par_q;

    // Stage 1: sample the parity result only for captured words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_vld <= 1'b0;
            stg_odd <= 1'b0;
            ppo     <= 1'b0;
        end else begin
            stg_vld <= cap_q;
            if (cap_q) begin
                stg_odd <= odd_now;
                ppo     <= odd_now;
            end
        end
    end

    // Stage 2: one-clock low pulse per failing word, unless masked.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_n <= 1'b1;
        else
            err_n <= ~(stg_vld & stg_odd & ~mask);
    end
endmodule

// File: rtl/sreg_parity_buffer.sv
// Top: registered command/address buffer with an even-parity checker.
// Assumes: single-device use; synchronous active-low reset.
module sreg_parity_buffer
    import sreg_pkg::*;
#(
    parameter int unsigned W          = SREG_W_DEFAULT,
    parameter int unsigned ACT_CYCLES = SREG_ACT_DEFAULT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sel_dev_n,
    input  logic         sel_reg_n,
    input  logic [W-1:0] d_in,
    input  logic         par_in,
    output logic [W-1:0] q_out,
    output logic         ppo,
    output logic         err_n
);
    logic cap;
    logic par_q;
    logic cap_q;
    logic act_mask;

    // Capture qualifier from both selects.
    always_comb cap = sel_active(sel_dev_n, sel_reg_n);

    sreg_capture #(.W(W)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap   (cap),
        .d     (d_in),
        .par   (par_in),
        .q     (q_out),
        .par_q (par_q),
        .cap_q (cap_q)
    );

    sreg_act_window #(.ACT_CYCLES(ACT_CYCLES)) u_act (
        .clk    (clk),
        .rst_n  (rst_n),
        .masked (act_mask)
    );

    sreg_parity_pipe #(.W(W)) u_par (
        .clk   (clk),
        .rst_n (rst_n),
        .q     (q_out),
        .par_q (par_q),
        .cap_q (cap_q),
        .mask  (act_mask),
        .ppo   (ppo),
        .err_n (err_n)
    );
endmodule

// File: rtl/sreg_parity_buffer_chk.sv
// Property checker for sreg_parity_buffer, attached by bind.
module sreg_parity_buffer_chk #(
    parameter int unsigned W = 25
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sel_dev_n,
    input logic         sel_reg_n,
    input logic [W-1:0] d_in,
    input logic         par_in,
    input logic [W-1:0] q_out,
    input logic         ppo,
    input logic         err_n,
    input logic         act_mask
);
    logic [2:0] since;
    logic       cap_c;
    logic       bad_c;

    // Edges seen with reset released, saturating at 7.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since <= '0;
        else if (since != 3'd7)
            since <= since + 1'b1;
    end

    always_comb begin
        cap_c = ~sel_dev_n & ~sel_reg_n;
        bad_c = (^d_in) ^ par_in;
    end

    // R1: capture copies the input word.
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd1 && cap_c) |=> (q_out == $past(d_in)));

    // R2: deselected cycles keep the word.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd1 && !cap_c) |=> $stable(q_out));

    // R4: a bad word, unmasked, shows as err_n low after three sample points.
    p_err_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd4 && $past(cap_c && bad_c, 3) && !$past(act_mask)) |-> !err_n);

    // R6: while the window mask is on, no error is reported.
    p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since >= 3'd2 && $past(act_mask)) |-> err_n);

    // R7: reset clears the outputs.
    p_reset_r7: assert property (@(posedge clk)
        !rst_n |=> (q_out == '0 && !ppo && err_n));
endmodule

bind sreg_parity_buffer sreg_parity_buffer_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_dev_n (sel_dev_n),
    .sel_reg_n (sel_reg_n),
    .d_in      (d_in),
    .par_in    (par_in),
    .q_out     (q_out),
    .ppo       (ppo),
    .err_n     (err_n),
    .act_mask  (act_mask)
);

// File: tb/sim_sreg_parity_buffer.sv
module sim_sreg_parity_buffer;
    localparam int PERIOD = 10;
    localparam int W      = 25;
    localparam int ACT    = 8;

    typedef struct {
        int          due;
        logic [W-1:0] val;
        string       tag;
    } item_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_dev_n = 1'b1;
    logic         sel_reg_n = 1'b1;
    logic [W-1:0] d_in = '0;
    logic         par_in = 1'b0;
    logic [W-1:0] q_out;
    logic         ppo;
    logic         err_n;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int since  = 0;
    logic [W-1:0] q_model = '0;
    logic prev_bad = 1'b0;
    item_t qq[$];
    item_t pq[$];
    item_t eq[$];

    sreg_parity_buffer #(.W(W), .ACT_CYCLES(ACT)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_dev_n(sel_dev_n), .sel_reg_n(sel_reg_n),
        .d_in(d_in), .par_in(par_in), .q_out(q_out), .ppo(ppo), .err_n(err_n)
    );

    always #(PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        since <= rst_n ? since + 1 : 0;
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s cycle=%0d actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // Driver: apply one word and push the expected results.
    task automatic drive(input logic [W-1:0] w, input logic p, input logic dn, input logic rn);
        int  e;
        logic cap;
        logic bad;
        item_t it;
        @(negedge clk);
        d_in = w; par_in = p; sel_dev_n = dn; sel_reg_n = rn;
        e   = cyc + 1;
        cap = !dn && !rn;
        bad = (^w) ^ p;
        if (cap) q_model = w;
        it.due = e; it.val = q_model; it.tag = cap ? "R1" : "R2";
        qq.push_back(it);
        if (cap) begin
            it.due = e + 1; it.val = W'(bad); it.tag = "R3";
            pq.push_back(it);
        end
        it.due = e + 2;
        if (cap && bad && (since + 2 < ACT)) begin
            it.val = W'(1); it.tag = "R6";
        end else if (cap && bad) begin
            it.val = W'(0); it.tag = "R4";
        end else begin
            it.val = W'(1);
            it.tag = !cap ? "R2" : (prev_bad ? "R5" : "R4");
        end
        eq.push_back(it);
        prev_bad = cap && bad && !(since + 2 < ACT);
    endtask

    // Monitor: compare design outputs against due expectations.
    always @(negedge clk) begin
        while (qq.size() > 0 && qq[0].due == cyc) begin
            check(qq[0].tag, q_out, qq[0].val); void'(qq.pop_front());
        end
        while (pq.size() > 0 && pq[0].due == cyc) begin
            check(pq[0].tag, W'(ppo), pq[0].val); void'(pq.pop_front());
        end
        while (eq.size() > 0 && eq[0].due == cyc) begin
            check(eq[0].tag, W'(err_n), eq[0].val); void'(eq.pop_front());
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic flush_idle(input int n);
        for (int i = 0; i < n; i++) drive('0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        logic [W-1:0] w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R7", q_out, '0); check("R7", W'(ppo), '0); check("R7", W'(err_n), W'(1));
        rst_n = 1'b1;
        // R6: bad parity right after release is masked.
        drive(25'h0000001, 1'b0, 1'b0, 1'b0);
        drive(25'h0000003, 1'b1, 1'b0, 1'b0);
        drive(25'h1000000, 1'b0, 1'b0, 1'b0);
        flush_idle(ACT + 2);
        // R1/R3/R4: good and bad words with several patterns.
        drive({W{1'b1}}, 1'b1, 1'b0, 1'b0);
        drive({W{1'b1}}, 1'b0, 1'b0, 1'b0);
        drive(25'h0AAAAAA, 1'b0, 1'b0, 1'b0);
        drive(25'h1555555, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < W; i++) drive(W'(1) << i, (i % 3 == 0) ? 1'b0 : 1'b1, 1'b0, 1'b0);
        // R5: back-to-back bad words then a good one.
        drive(25'h0000007, 1'b0, 1'b0, 1'b0);
        drive(25'h0000001, 1'b0, 1'b0, 1'b0);
        drive(25'h0000003, 1'b0, 1'b0, 1'b0);
        drive(25'h0000003, 1'b0, 1'b0, 1'b0);
        // R2: deselected cycles with bad parity and changing data.
        drive(25'h1234567, 1'b1, 1'b1, 1'b0);
        drive(25'h0FEDCBA, 1'b0, 1'b0, 1'b1);
        drive(25'h0000001, 1'b0, 1'b1, 1'b1);
        drive(25'h0000000, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 40; i++) begin
            w = W'($urandom);
            drive(w, (i % 2 == 0) ? ^w : ~(^w), (i % 7 == 3) ? 1'b1 : 1'b0, 1'b0);
        end
        flush_idle(4);
        // R7: bad word just before reset is never reported.
        drive(25'h0000001, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b0; sel_dev_n = 1'b1; sel_reg_n = 1'b1;
        qq.delete(); pq.delete(); eq.delete();
        prev_bad = 1'b0;
        q_model = '0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check("R7", q_out, '0); check("R7", W'(ppo), '0); check("R7", W'(err_n), W'(1));
        end
        rst_n = 1'b1;
        flush_idle(ACT + 2);
        drive(25'h0000005, 1'b1, 1'b0, 1'b0);
        flush_idle(4);
        finish_run();
    end
endmodule